// File: doc/BRIEF.md
# Dual-Clock Tuning Register Loader

This block is the host-facing write port for the tuning registers of a numerically controlled oscillator. The host places a 16-bit word and a 3-bit address on the bus, then pulses an active-low write strobe. The word and the address are captured on the rising edge of the strobe, in the strobe's own timing domain.

The capture is signalled to the master-clock domain by flipping a toggle bit. The toggle passes through a two-stage synchronizer, and the captured word and address travel in step with it. When a toggle change is detected, exactly one register update is made.

The register set holds two 32-bit frequency words and four 12-bit phase offsets. Each frequency word is written as two separate 16-bit halves. All six values are driven continuously to the oscillator core. The oscillator reset clears only the handoff logic and leaves the register contents alone, so software must write zeros after power-up.

Top module: `ncoreg_loader`

## Requirements
- R1: `addr` and `data` are captured only on the rising edge of `wr_n`. Bus changes made after that edge, while `wr_n` stays high, have no effect on the value written.
- R2: A write whose strobe edge falls between master-clock edges E0 and E1 is not visible after E2. It is visible after E3.
- R3: Writing one half of a frequency word changes only that half. The other half keeps its value, so the core can see the mixed value between two half-writes.
- R4: Address 3'b000 writes `freq0[15:0]`, and address 3'b001 writes `freq0[31:16]`.
- R5: Address 3'b010 writes `freq1[15:0]`, and address 3'b011 writes `freq1[31:16]`.
- R6: Addresses 3'b100, 3'b101, 3'b110 and 3'b111 write `phase0`, `phase1`, `phase2` and `phase3`. Only `data[11:0]` is stored, and `data[15:12]` is ignored.
- R7: While no strobe edge occurs, all six register outputs hold their values, whatever the bus carries.
- R8: Asserting `rst_n` leaves every register value unchanged, and it produces no register update during or after reset.
- R9: Strobes may arrive once per master-clock cycle. Each one is applied exactly once, in arrival order, so the last write to an address wins.
- R10: A strobe edge just before a master-clock edge and one just after it are each committed exactly once, to the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset of the handoff logic only |
| wr_n | input | 1 | Active-low write strobe; its rising edge captures the bus |
| addr | input | 3 | Destination select |
| data | input | 16 | Write data |
| freq0 | output | 32 | Frequency word 0 |
| freq1 | output | 32 | Frequency word 1 |
| phase0 | output | 12 | Phase offset 0 |
| phase1 | output | 12 | Phase offset 1 |
| phase2 | output | 12 | Phase offset 2 |
| phase3 | output | 12 | Phase offset 3 |

## Verification
Isolated writes cover all eight addresses, with the strobe edge placed half a nanosecond before a clock edge and half a nanosecond after one. These writes also leave the bus holding garbage right after the strobe. Any mis-decoded address, any phase word that keeps its top nibble, and any capture taken from the live bus therefore shows up against the model. A write to one frequency half with the other half still old catches an update that disturbs the wrong half. A burst of one strobe per clock, including a repeated address, separates lost, duplicated or reordered commits. A latency probe, a quiet-bus interval and a reset pulse in the middle of the run show that nothing commits early, nothing commits without a strobe, and reset neither erases the registers nor injects a phantom update.

// File: rtl/ncoreg_pkg.sv
`timescale 1ns/1ps
package ncoreg_pkg;
    // Destination encoding; the numeric values are the host address map.
    typedef enum logic [2:0] {
        DST_F0_LO = 3'b000,
        DST_F0_HI = 3'b001,
        DST_F1_LO = 3'b010,
        DST_F1_HI = 3'b011,
        DST_PH0   = 3'b100,
        DST_PH1   = 3'b101,
        DST_PH2   = 3'b110,
        DST_PH3   = 3'b111
    } dest_e;
endpackage

// File: rtl/ncoreg_capture.sv
`timescale 1ns/1ps
// Strobe-domain capture: latches bus on rising wr_n and flips a toggle.
module ncoreg_capture #(
    parameter int PW = 19
) (
    input  logic          wr_n,
    input  logic          rst_n,
    input  logic [PW-1:0] bus_in,
    output logic          tog,
    output logic [PW-1:0] cap
);
    always_ff @(posedge wr_n or negedge rst_n) begin
        if (!rst_n) tog <= 1'b0;
        else        tog <= ~tog;
    end

    always_ff @(posedge wr_n) begin
        cap <= bus_in;
    end
endmodule

// File: rtl/ncoreg_sync.sv
`timescale 1ns/1ps
// Master-clock side: toggle synchronizer with payload carried in lockstep.
module ncoreg_sync #(
    parameter int STAGES = 2,
    parameter int PW     = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tog_in,
    input  logic [PW-1:0] pay_in,
    output logic          commit,
    output logic [PW-1:0] pay_out
);
    logic [STAGES-1:0]         tq;
    logic [STAGES-1:0][PW-1:0] pq;
    logic                      seen;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("ncoreg_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tq   <= '0;
            seen <= 1'b0;
        end else begin
            tq   <= {tq[STAGES-2:0], tog_in};
            seen <= tq[STAGES-1];
        end
    end

    always_ff @(posedge clk) begin
        pq <= {pq[STAGES-2:0], pay_in};
    end

    assign commit  = tq[STAGES-1] ^ seen;
    assign pay_out = pq[STAGES-1];
endmodule

// File: rtl/ncoreg_bank.sv
`timescale 1ns/1ps
// Register bank: no reset, one update per commit pulse.
module ncoreg_bank
    import ncoreg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FREQ_W = 32,
    parameter int PH_W   = 12
) (
    input  logic              clk,
    input  logic              commit,
    input  dest_e             dest,
    input  logic [DATA_W-1:0] wdata,
    output logic [FREQ_W-1:0] freq0,
    output logic [FREQ_W-1:0] freq1,
    output logic [PH_W-1:0]   phase0,
    output logic [PH_W-1:0]   phase1,
    output logic [PH_W-1:0]   phase2,
    output logic [PH_W-1:0]   phase3
);
    localparam int HALF = FREQ_W / 2;

    always_ff @(posedge clk) begin
        if (commit) begin
            unique case (dest)
                DST_F0_LO: freq0[HALF-1:0]      <= wdata[HALF-1:0];
                DST_F0_HI: freq0[FREQ_W-1:HALF] <= wdata[HALF-1:0];
                DST_F1_LO: freq1[HALF-1:0]      <= wdata[HALF-1:0];
                DST_F1_HI: freq1[FREQ_W-1:HALF] <= wdata[HALF-1:0];
                DST_PH0:   phase0               <= wdata[PH_W-1:0];
                DST_PH1:   phase1               <= wdata[PH_W-1:0];
                DST_PH2:   phase2               <= wdata[PH_W-1:0];
                DST_PH3:   phase3               <= wdata[PH_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/ncoreg_loader.sv
`timescale 1ns/1ps
module ncoreg_loader
    import ncoreg_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FREQ_W      = 32,
    parameter int PH_W        = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] data,
    output logic [FREQ_W-1:0] freq0,
    output logic [FREQ_W-1:0] freq1,
    output logic [PH_W-1:0]   phase0,
    output logic [PH_W-1:0]   phase1,
    output logic [PH_W-1:0]   phase2,
    output logic [PH_W-1:0]   phase3
);
    localparam int PW = DATA_W + 3;

    logic          tog;
    logic [PW-1:0] cap;
    logic [PW-1:0] c_pay;
    logic          commit;
    logic [2:0]    c_addr;
    logic [DATA_W-1:0] c_data;

    ncoreg_capture #(.PW(PW)) u_cap (
        .wr_n   (wr_n),
        .rst_n  (rst_n),
        .bus_in ({addr, data}),
        .tog    (tog),
        .cap    (cap)
    );

    ncoreg_sync #(.STAGES(SYNC_STAGES), .PW(PW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog_in  (tog),
        .pay_in  (cap),
        .commit  (commit),
        .pay_out (c_pay)
    );

    assign c_addr = c_pay[PW-1:DATA_W];
    assign c_data = c_pay[DATA_W-1:0];

    ncoreg_bank #(.DATA_W(DATA_W), .FREQ_W(FREQ_W), .PH_W(PH_W)) u_bank (
        .clk    (clk),
        .commit (commit),
        .dest   (dest_e'(c_addr)),
        .wdata  (c_data),
        .freq0  (freq0),
        .freq1  (freq1),
        .phase0 (phase0),
        .phase1 (phase1),
        .phase2 (phase2),
        .phase3 (phase3)
    );
endmodule

// File: rtl/ncoreg_loader_chk.sv
`timescale 1ns/1ps
module ncoreg_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        commit,
    input logic [2:0]  c_addr,
    input logic [15:0] c_data,
    input logic [31:0] freq0,
    input logic [31:0] freq1,
    input logic [11:0] phase0,
    input logic [11:0] phase1,
    input logic [11:0] phase2,
    input logic [11:0] phase3
);
    a_r4_f0_low: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && c_addr == 3'b000) |=> freq0[15:0] == $past(c_data));

    a_r5_f1_high: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && c_addr == 3'b011) |=> freq1[31:16] == $past(c_data));

    a_r6_phase2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && c_addr == 3'b110) |=> phase2 == $past(c_data[11:0]));

    a_r3_other_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && c_addr == 3'b001) |=> freq0[15:0] === $past(freq0[15:0]));

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (freq0 === $past(freq0)) && (freq1 === $past(freq1)) &&
                    (phase0 === $past(phase0)) && (phase1 === $past(phase1)) &&
                    (phase2 === $past(phase2)) && (phase3 === $past(phase3)));
endmodule

bind ncoreg_loader ncoreg_loader_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .c_addr (c_addr),
    .c_data (c_data),
    .freq0  (freq0),
    .freq1  (freq1),
    .phase0 (phase0),
    .phase1 (phase1),
    .phase2 (phase2),
    .phase3 (phase3)
);

// File: tb/ncoreg_loader_tb.sv
`timescale 1ns/1ps
module ncoreg_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [2:0]  addr = 3'b000;
    logic [15:0] data = 16'h0000;
    logic [31:0] freq0, freq1;
    logic [11:0] phase0, phase1, phase2, phase3;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_f0, m_f1;
    logic [11:0] m_p0, m_p1, m_p2, m_p3;

    always #2 clk = ~clk;

    ncoreg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .data(data),
        .freq0(freq0), .freq1(freq1),
        .phase0(phase0), .phase1(phase1), .phase2(phase2), .phase3(phase3)
    );

    // {addr, data, strobe edge late (1) or early (0) in the cycle}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {3'b000, 16'h0000, 1'b1}, {3'b001, 16'h0000, 1'b0},
        {3'b010, 16'h0000, 1'b1}, {3'b011, 16'h0000, 1'b0},
        {3'b100, 16'h0000, 1'b1}, {3'b101, 16'h0000, 1'b0},
        {3'b110, 16'h0000, 1'b1}, {3'b111, 16'h0000, 1'b0},
        {3'b000, 16'h1234, 1'b1}, {3'b001, 16'hABCD, 1'b0},
        {3'b011, 16'h5A5A, 1'b1}, {3'b010, 16'hC3C3, 1'b0},
        {3'b101, 16'hF7E1, 1'b1}, {3'b110, 16'h9ABC, 1'b0}
    };

    function automatic logic [111:0] dut_all();
        return {freq0, freq1, phase0, phase1, phase2, phase3};
    endfunction

    function automatic logic [111:0] mdl_all();
        return {m_f0, m_f1, m_p0, m_p1, m_p2, m_p3};
    endfunction

    task automatic model_apply(input logic [2:0] a, input logic [15:0] d);
        case (a)
            3'b000: m_f0[15:0]  = d;
            3'b001: m_f0[31:16] = d;
            3'b010: m_f1[15:0]  = d;
            3'b011: m_f1[31:16] = d;
            3'b100: m_p0 = d[11:0];
            3'b101: m_p1 = d[11:0];
            3'b110: m_p2 = d[11:0];
            default: m_p3 = d[11:0];
        endcase
    endtask

    task automatic check_all(input string req);
        n_chk++;
        if (dut_all() !== mdl_all()) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, dut_all(), mdl_all());
        end
    endtask

    // One isolated write; off is the rise delay after a clock edge (ns).
    task automatic do_write(input logic [2:0] a, input logic [15:0] d, input real off);
        @(negedge clk);
        addr = a; data = d; wr_n = 1'b0;
        @(posedge clk);
        #(off);
        wr_n = 1'b1;
        model_apply(a, d);
        #0.2;
        addr = ~a; data = ~d;   // R1: bus garbage after the capture edge
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // Table walk: R4, R5, R6, R1, R10 (late = just before next edge, early = just after)
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][19:17], VEC[i][16:1], VEC[i][0] ? 3.5 : 0.5);
            repeat (4) @(posedge clk);
            #1;
            check_all("R4 R5 R6 R1 R10 vector");
        end

        // R3: low half of freq1 changed, high half from earlier remains
        do_write(3'b010, 16'h0F0F, 1.0);
        repeat (4) @(posedge clk);
        #1;
        n_chk++;
        if (freq1 !== {16'h5A5A, 16'h0F0F}) begin
            n_fail++;
            $display("FAIL R3: actual %h expected %h", freq1, {16'h5A5A, 16'h0F0F});
        end

        // R6: top nibble ignored, phase3
        do_write(3'b111, 16'hFFFF, 2.0);
        repeat (4) @(posedge clk);
        #1;
        n_chk++;
        if (phase3 !== 12'hFFF) begin
            n_fail++;
            $display("FAIL R6: actual %h expected %h", phase3, 12'hFFF);
        end

        // R2: latency, strobe edge at E0+1
        do_write(3'b100, 16'h0246, 1.0);
        @(posedge clk); @(posedge clk);
        #1;
        n_chk++;
        if (phase0 !== 12'h000) begin
            n_fail++;
            $display("FAIL R2 early: actual %h expected %h", phase0, 12'h000);
        end
        @(posedge clk);
        #1;
        n_chk++;
        if (phase0 !== 12'h246) begin
            n_fail++;
            $display("FAIL R2 on time: actual %h expected %h", phase0, 12'h246);
        end

        // R7: bus activity with no strobe
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            addr = 3'(k); data = 16'(k * 16'h1111);
        end
        repeat (4) @(posedge clk);
        #1;
        check_all("R7 idle bus");

        // R9: one strobe per clock, repeated address, order matters
        begin
            logic [2:0]  ba [6] = '{3'b000, 3'b101, 3'b000, 3'b011, 3'b111, 3'b101};
            logic [15:0] bd [6] = '{16'h1111, 16'h0AAA, 16'h2222, 16'h7777, 16'h0333, 16'h0BBB};
            @(negedge clk);
            addr = ba[0]; data = bd[0]; wr_n = 1'b0;
            for (int k = 0; k < 6; k++) begin
                @(posedge clk);
                #1 wr_n = 1'b1;
                model_apply(ba[k], bd[k]);
                #0.5;
                if (k < 5) begin
                    addr = ba[k+1]; data = bd[k+1]; wr_n = 1'b0;
                end
            end
            repeat (5) @(posedge clk);
            #1;
            check_all("R9 back-to-back");
        end

        // R8: reset pulse keeps registers, no phantom update afterwards
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check_all("R8 during reset");
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check_all("R8 after reset");

        // R8 then R10: first write after reset is committed once
        do_write(3'b001, 16'h4321, 3.5);
        repeat (4) @(posedge clk);
        #1;
        check_all("R10 after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule